// File: doc/BRIEF.md
# Fractional UART Baud Generator

This block derives the two timing strobes a UART needs from its peripheral clock: a one-cycle pulse at sixteen times the bit rate, used for oversampling, and a one-cycle pulse once per bit. A 16-bit integer divisor, written as a low byte and a high byte, sets the coarse rate. A fractional pre-scaler, controlled by a 4-bit multiplier and a 4-bit add value, stretches the clock by a further factor of (1 + add/mul). This gives a finer choice of baud rates than an integer counter can give on its own.

Software programs the block through a small byte-wide write port and starts it with `enable`. The resulting bit rate is PCLK / (16 × D × (1 + A/M)), where D is the divisor, A is the add value and M is the multiplier. The pre-scaler is a phase accumulator. On each clock where it passes the clock on, it adds A. When the accumulator has reached M, it instead holds back one clock enable and subtracts M. Held-back cycles are therefore never adjacent, and the spacing of the strobes jitters by at most one clock.

A small controller sequences the counters. It has three states. ST_IDLE means stopped, with both strobes low. ST_LOAD means the counters and the accumulator are cleared and the divisor is reloaded. ST_RUN means counting. The transitions are as follows:
- ST_IDLE goes to ST_LOAD when `enable` is high.
- ST_LOAD always goes to ST_RUN.
- ST_RUN goes to ST_IDLE when `enable` falls.
- From any state, a write to a mapped register goes to ST_LOAD if `enable` is high, or to ST_IDLE if it is low.

Top module: `baud_frac_gen`

## Requirements
- R1: After reset the divisor is 0, the add value is 0 and the multiplier is 1, and both strobes are low. Once `enable` is raised with these settings, `tick_x16` is high on every clock.
- R2: The write map is as follows:
  - Address 0 holds divisor bits 7:0.
  - Address 1 holds divisor bits 15:8.
  - Address 2 holds the fractional setting, with the add value in data bits 3:0 and the multiplier in data bits 7:4.
- R3: For valid settings (1 ≤ M ≤ 15, A < M), the `tick_x16` period averages D×(M+A)/M clocks, where a divisor of 0 counts as 1. The `tick_bit` period averages 16 times that. The total over any run of whole periods is within one clock of this value.
- R4: With A = 0, every `tick_x16` period is exactly D clocks. With A > 0, individual periods differ from each other by at most one clock, and the pre-scaler never holds back two clock enables in a row.
- R5: `tick_bit` pulses once for every 16 `tick_x16` pulses, one clock after the sixteenth of them.
- R6: From the second clock after `enable` is sampled low, both strobes stay low.
- R7: A write to a mapped address restarts the block from a clean phase. Both strobes are low on the second clock after the write. With A = 0, the first `tick_x16` is high D+1 clocks after the write edge.
- R8: A write to address 3 changes no setting and does not disturb the phase of the strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| enable | input | 1 | Run the generator |
| tick_x16 | output | 1 | One-cycle pulse at 16× the bit rate |
| tick_bit | output | 1 | One-cycle pulse once per bit |

## Verification
The assertions check the following on every cycle:
- Both strobes are silent after `enable` drops and after a restart.
- Each bit strobe is preceded by an oversampling strobe.
- Exactly sixteen oversampling strobes fall between bit strobes.
- The pre-scaler never holds back two clock enables in a row while the settings are valid.

Only the bench's scenarios can show the following:
- The average period matches the rate formula for a given divisor and fractional setting, including the high byte and a divisor of zero.
- The jitter stays within one clock.
- The first strobe arrives at the right time after a write.
- A write to the unused address leaves the phase untouched.

// File: rtl/baud_pkg.sv
package baud_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_RUN  = 2'd2
    } gen_state_t;

endpackage

// File: rtl/baud_regs.sv
module baud_regs #(
    parameter int DIV_W  = 16,
    parameter int FRAC_W = 4,
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DIV_W-1:0]  div_val,
    output logic [FRAC_W-1:0] frac_add,
    output logic [FRAC_W-1:0] frac_mul,
    output logic              restart
);
    localparam int NLANES = DIV_W / DATA_W;
    localparam logic [ADDR_W-1:0] FRAC_ADDR = ADDR_W'(NLANES);

    logic [DATA_W-1:0] lane_q [NLANES];

    // One register per divisor byte lane, placed at consecutive addresses.
    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lane_q[g] <= '0;
            end else if (wr_en && wr_addr == ADDR_W'(g)) begin
                lane_q[g] <= wr_data;
            end
        end
        assign div_val[g*DATA_W +: DATA_W] = lane_q[g];
    end

    // Fractional setting: add value in the low field, multiplier above it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frac_add <= '0;
            frac_mul <= FRAC_W'(1);
        end else if (wr_en && wr_addr == FRAC_ADDR) begin
            frac_add <= wr_data[FRAC_W-1:0];
            frac_mul <= wr_data[2*FRAC_W-1:FRAC_W];
        end
    end

    assign restart = wr_en && (wr_addr <= FRAC_ADDR);

endmodule

// File: rtl/baud_frac.sv
module baud_frac #(
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [FRAC_W-1:0] frac_add,
    input  logic [FRAC_W-1:0] frac_mul,
    output logic              ce
);
    localparam int ACC_W = FRAC_W + 1;

    logic [ACC_W-1:0] acc_q;
    logic             owe;

    assign owe = (acc_q >= {1'b0, frac_mul});

    // A zero add value bypasses the stage entirely.
    assign ce = run && ((frac_add == '0) || !owe);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (!run) begin
            acc_q <= '0;
        end else if (frac_add != '0) begin
            if (owe) begin
                acc_q <= acc_q - {1'b0, frac_mul};
            end else begin
                acc_q <= acc_q + ACC_W'(frac_add);
            end
        end
    end

endmodule

// File: rtl/baud_div.sv
module baud_div
    import baud_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int OVS   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             restart,
    input  logic             ce,
    input  logic [DIV_W-1:0] div_val,
    output logic             run,
    output logic             tick_x16,
    output logic             tick_bit
);
    localparam int OVS_W = $clog2(OVS);
    localparam logic [OVS_W-1:0] OVS_LAST = OVS_W'(OVS - 1);

    gen_state_t       state_q, state_d;
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] reload;
    logic [OVS_W-1:0] ovs_q;

    assign reload = (div_val == '0) ? '0 : div_val - DIV_W'(1);
    assign run    = (state_q == ST_RUN);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (enable) state_d = ST_LOAD;
            ST_LOAD: state_d = ST_RUN;
            ST_RUN:  if (!enable) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
        if (restart) begin
            state_d = enable ? ST_LOAD : ST_IDLE;
        end
    end

    // Counters and registered strobes.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            ovs_q    <= '0;
            tick_x16 <= 1'b0;
            tick_bit <= 1'b0;
        end else begin
            unique case (state_q)
                ST_LOAD: begin
                    cnt_q    <= reload;
                    ovs_q    <= '0;
                    tick_x16 <= 1'b0;
                    tick_bit <= 1'b0;
                end
                ST_RUN: begin
                    tick_x16 <= ce && (cnt_q == '0);
                    if (ce) begin
                        cnt_q <= (cnt_q == '0) ? reload : cnt_q - DIV_W'(1);
                    end
                    tick_bit <= tick_x16 && (ovs_q == OVS_LAST);
                    if (tick_x16) begin
                        ovs_q <= ovs_q + OVS_W'(1);
                    end
                end
                default: begin
                    tick_x16 <= 1'b0;
                    tick_bit <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/baud_frac_gen.sv
module baud_frac_gen #(
    parameter int DIV_W  = 16,
    parameter int FRAC_W = 4,
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              enable,
    output logic              tick_x16,
    output logic              tick_bit
);
    logic [DIV_W-1:0]  div_val;
    logic [FRAC_W-1:0] frac_add;
    logic [FRAC_W-1:0] frac_mul;
    logic              restart;
    logic              run;
    logic              ce;

    baud_regs #(
        .DIV_W (DIV_W),
        .FRAC_W(FRAC_W),
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .div_val (div_val),
        .frac_add(frac_add),
        .frac_mul(frac_mul),
        .restart (restart)
    );

    baud_frac #(
        .FRAC_W(FRAC_W)
    ) u_frac (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .frac_add(frac_add),
        .frac_mul(frac_mul),
        .ce      (ce)
    );

    baud_div #(
        .DIV_W(DIV_W),
        .OVS  (OVS)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .restart (restart),
        .ce      (ce),
        .div_val (div_val),
        .run     (run),
        .tick_x16(tick_x16),
        .tick_bit(tick_bit)
    );

endmodule

// File: rtl/baud_frac_gen_chk.sv
module baud_frac_gen_chk #(
    parameter int FRAC_W = 4,
    parameter int OVS    = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              restart,
    input logic              run,
    input logic              ce,
    input logic [FRAC_W-1:0] frac_add,
    input logic [FRAC_W-1:0] frac_mul,
    input logic              tick_x16,
    input logic              tick_bit
);
    localparam int CW = $clog2(OVS) + 2;

    logic [CW-1:0] x16_seen;

    // Counts oversampling strobes since the last bit strobe.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x16_seen <= '0;
        end else if (!run) begin
            x16_seen <= '0;
        end else if (tick_bit) begin
            x16_seen <= tick_x16 ? CW'(1) : '0;
        end else if (tick_x16) begin
            x16_seen <= x16_seen + CW'(1);
        end
    end

    // R6: strobes silent once enable has been low for two samples back.
    p_idle_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!enable, 2) |-> (!tick_x16 && !tick_bit));

    // R7: restart clears both strobes.
    p_restart_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(restart, 2) |-> (!tick_x16 && !tick_bit));

    // R5: every bit strobe follows an oversampling strobe.
    p_bit_follows_x16_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tick_bit |-> $past(tick_x16));

    // R5: sixteen oversampling strobes per bit strobe.
    p_bit_every16_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tick_bit |-> (x16_seen == CW'(OVS)));

    // R4: the pre-scaler never holds back two enables in a row.
    p_one_suppress_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !$past(ce) && (frac_add < frac_mul)) |-> ce);

endmodule

bind baud_frac_gen baud_frac_gen_chk #(
    .FRAC_W(FRAC_W),
    .OVS   (OVS)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .restart (restart),
    .run     (run),
    .ce      (ce),
    .frac_add(frac_add),
    .frac_mul(frac_mul),
    .tick_x16(tick_x16),
    .tick_bit(tick_bit)
);

// File: tb/sim_baud_frac_gen.sv
module sim_baud_frac_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       enable = 1'b0;
    logic       tick_x16;
    logic       tick_bit;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    baud_frac_gen u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .enable  (enable),
        .tick_x16(tick_x16),
        .tick_bit(tick_bit)
    );

    // {lo byte, hi byte, multiplier, add value}
    localparam logic [23:0] VEC [0:6] = '{
        {8'd4, 8'd0, 4'd1,  4'd0},
        {8'd0, 8'd0, 4'd1,  4'd0},
        {8'd5, 8'd0, 4'd2,  4'd1},
        {8'd3, 8'd0, 4'd7,  4'd5},
        {8'd2, 8'd0, 4'd15, 4'd14},
        {8'd0, 8'd1, 4'd1,  4'd0},
        {8'd7, 8'd0, 4'd13, 4'd6}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Returns the number of samples until tick_x16 is seen (capped).
    task automatic until_x16(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!tick_x16 && n < 100000);
    endtask

    task automatic measure(input logic [23:0] v);
        int lo, hi, m, a, d, k, n, tot, mn, mx, nx, tb;
        lo = v[23:16]; hi = v[15:8]; m = v[7:4]; a = v[3:0];
        d = hi * 256 + lo;
        if (d == 0) d = 1;
        wr(2'd0, v[23:16]);
        wr(2'd1, v[15:8]);
        wr(2'd2, v[7:0]);
        until_x16(n);
        k = 2 * m;
        tot = 0; mn = 1 << 30; mx = 0;
        for (int p = 0; p < k; p++) begin
            until_x16(n);
            tot += n;
            if (n < mn) mn = n;
            if (n > mx) mx = n;
        end
        // R3: average oversampling period
        check((tot * m - k * d * (m + a)) <= m && (k * d * (m + a) - tot * m) <= m,
              "R3", "x16 total over periods (scaled by mul)", tot * m, k * d * (m + a));
        // R4: jitter of individual periods
        if (a == 0)
            check(mn == d && mx == d, "R4", "x16 period with no fraction", mx, d);
        else
            check(mx - mn <= 1, "R4", "x16 period spread", mx - mn, 1);
        // R5 and R3 on the bit strobe
        n = 0;
        while (!tick_bit && n < 100000) begin @(negedge clk); n++; end
        tot = 0;
        for (int p = 0; p < 2; p++) begin
            nx = tick_x16 ? 1 : 0;
            tb = 0;
            do begin
                @(negedge clk);
                tb++;
                if (!tick_bit && tick_x16) nx++;
            end while (!tick_bit && tb < 100000);
            tot += tb;
            check(nx == 16, "R5", "x16 strobes per bit strobe", nx, 16);
        end
        check((tot * m - 32 * d * (m + a)) <= m && (32 * d * (m + a) - tot * m) <= m,
              "R3", "bit total over two periods (scaled by mul)", tot * m, 32 * d * (m + a));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n, quiet, hits;
        repeat (3) @(negedge clk);
        // R1: reset state, strobes low
        check(!tick_x16 && !tick_bit, "R1", "strobes during reset", tick_x16, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(!tick_x16 && !tick_bit, "R1", "strobes while disabled", tick_x16, 0);
        enable = 1'b1;
        repeat (3) @(negedge clk);
        hits = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (tick_x16) hits++;
        end
        // R1: divisor 0 treated as 1 and fraction off after reset
        check(hits == 20, "R1", "x16 strobes in 20 clocks with reset settings", hits, 20);

        // Table walk: R2 (map), R3, R4, R5
        for (int i = 0; i < 7; i++) measure(VEC[i]);

        // R6: enable low silences the strobes
        wr(2'd0, 8'd2); wr(2'd1, 8'd0); wr(2'd2, 8'h10);
        repeat (10) @(negedge clk);
        enable = 1'b0;
        repeat (2) @(negedge clk);
        quiet = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (tick_x16 || tick_bit) quiet++;
        end
        check(quiet == 0, "R6", "strobes while disabled", quiet, 0);
        enable = 1'b1;

        // R7: first strobe D+1 clocks after a write
        wr(2'd0, 8'd5);
        repeat (20) @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'd3;
        @(negedge clk);
        wr_en = 1'b0;
        until_x16(n);
        check(n == 4, "R7", "clocks from write to first x16", n, 4);

        // R8: write to address 3 leaves the phase alone
        wr(2'd0, 8'd6);
        until_x16(n);
        until_x16(n);
        wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'hFF;
        @(negedge clk);
        wr_en = 1'b0;
        n = 1;
        while (!tick_x16 && n < 1000) begin @(negedge clk); n++; end
        check(n == 6, "R8", "x16 period across address-3 write", n, 6);
        until_x16(n);
        check(n == 6, "R8", "x16 period after address-3 write", n, 6);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule